// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block gathers single-cycle event pulses from one serial controller channel into two 8-bit pending-event registers, A and B. Register A takes eight receive-side events from outside. Register B takes transmit-side and line events. Two of those B events are produced inside the block from the clear-to-send (CTS) level and the transmitter state. Each pending register has a write-only enable mask. The block combines pending bits that are set and not masked into three outputs: an interrupt line, a two-bit group summary (one bit per register) and a vector-valid flag with the index of the highest-priority source.

A visibility control bit chooses what happens to events whose mask bit is set. With visibility off, those events are dropped. With visibility on, they are latched and can be read, but they still raise nothing. Software reads a pending register through a small select/strobe port. A read returns the latched bits and clears them at the clock edge that ends the read cycle. An event that arrives in that same cycle survives the clear.

Top module: `irq_status_ctrl`

## Requirements
- R1: Synchronous reset sets both masks to all ones, clears both pending registers and the visibility bit, and holds `irq_o`, `gsum_o` and `vec_valid_o` low.
- R2: A mask bit of 1 disables the matching pending bit and a mask bit of 0 enables it. A mask write takes effect on the outputs in the cycle after the write edge.
- R3: A pending bit whose mask is 1 never raises `irq_o` or `vec_valid_o`, never sets a `gsum_o` bit, and is never chosen as `vec_idx_o`.
- R4: With visibility 0, an event whose mask bit is 1 is not latched. With visibility 1, it is latched and reads back as 1.
- R5: Pending bit B2 is set one cycle after any change of `cts_i`, on both rising and falling edges. A read of select 3 returns the registered CTS level in bit 0 and zeros in the other bits.
- R6: A read strobe (`rd_en`=1) returns the selected register on `rd_data` during that cycle. For select 0 or 1, the register is cleared at the closing edge.
- R7: An event that arrives in the same cycle as a clearing read of its register is still set after that edge.
- R8: `irq_o` is the OR of all enabled pending bits, and it drops once those bits are read-cleared or masked. `gsum_o[0]` reflects register A and `gsum_o[1]` reflects register B; each is 1 when its register has at least one enabled pending bit. Read select 2 returns `gsum_o` in bits 1:0.
- R9: `vec_valid_o` equals `irq_o`. `vec_idx_o` gives the lowest-numbered enabled pending source, where A bit n is index n and B bit n is index 8+n.
- R10: Pending bit B1 (transmit repeat) is set when `bus_mode`=1 and `tx_collide`=1. It is also set when `bus_mode`=0, `tx_busy`=1 and CTS falls from 1 to 0. CTS falling while `tx_busy`=0 sets only B2. CTS is active high.
- R11: Register B layout: bit0 transmit pool ready, bit1 transmit repeat, bit2 CTS change, bit3 timer, bit4 underrun, bit5 all sent. Bits 7:6 are unused: they are held at 1 in mask B whatever is written, and they always read 0.
- R12: Write select 0 loads mask A, select 1 loads mask B, and select 2 loads the visibility bit from `wr_data[0]`. Read select 0 returns register A and select 1 returns register B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 mask A, 1 mask B, 2 control |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; clears pending register 0 or 1 |
| rd_sel | input | 2 | Read source: 0 A, 1 B, 2 summary, 3 line level |
| rd_data | output | 8 | Combinational read data |
| ev_rx | input | 8 | Receive-side event pulses into register A |
| ev_xpr | input | 1 | Transmit pool ready pulse |
| ev_tmr | input | 1 | Timer expired pulse |
| ev_xdu | input | 1 | Transmit underrun pulse |
| ev_alls | input | 1 | All sent pulse |
| tx_collide | input | 1 | Character collision in bus mode |
| tx_busy | input | 1 | A character is being transmitted |
| bus_mode | input | 1 | 1 = bus configuration, 0 = point-to-point |
| cts_i | input | 1 | Clear-to-send level, active high |
| irq_o | output | 1 | Interrupt request |
| gsum_o | output | 2 | Per-register enabled-pending summary |
| vec_valid_o | output | 1 | A vector index is being presented |
| vec_idx_o | output | 4 | Index of highest-priority enabled source |

## Verification
The hardest state to reach is a pending bit that was latched while it was masked under visibility 1, and that then becomes enabled when the mask is rewritten. At that moment the interrupt must appear with no new event. A second hard case is the transmit-repeat bit in point-to-point mode, which needs CTS to fall while a character is in flight. The stimulus reaches both with directed sequences: enable visibility, pulse a masked source, read it back, then clear its mask. For the second case it toggles CTS with `tx_busy` both high and low. A long random phase then mixes reads, mask writes and CTS edges in the same cycles, against a behavioural model checked on every clock.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;

    localparam int DW    = 8;
    localparam int NBANK = 2;
    localparam int NSRC  = NBANK * DW;
    localparam int IDXW  = $clog2(NSRC);
    localparam int SELW  = 2;

    typedef enum logic [SELW-1:0] {
        WR_MASK_A = 2'd0,
        WR_MASK_B = 2'd1,
        WR_CTRL   = 2'd2,
        WR_NONE   = 2'd3
    } wr_sel_e;

    typedef enum logic [SELW-1:0] {
        RD_STAT_A = 2'd0,
        RD_STAT_B = 2'd1,
        RD_GSUM   = 2'd2,
        RD_LINE   = 2'd3
    } rd_sel_e;

    // register B bit positions
    localparam int B_XPR  = 0;
    localparam int B_REP  = 1;
    localparam int B_CTS  = 2;
    localparam int B_TMR  = 3;
    localparam int B_XDU  = 4;
    localparam int B_ALLS = 5;

    localparam logic [DW-1:0] B_UNUSED = 8'hC0;

    typedef struct packed {
        logic vis;
    } ctrl_t;

    typedef struct packed {
        logic cts_lvl;
        logic cts_chg;
        logic rep;
    } line_ev_t;

    function automatic logic [DW-1:0] forced_bits(input int bank);
        return (bank == 1) ? B_UNUSED : '0;
    endfunction

    function automatic logic [IDXW-1:0] first_set(input logic [NSRC-1:0] v);
        logic [IDXW-1:0] r;
        r = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (v[i]) r = IDXW'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_line_events.sv
module irq_line_events
    import irq_status_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cts_i,
    input  logic     bus_mode,
    input  logic     tx_collide,
    input  logic     tx_busy,
    output line_ev_t ev
);

    logic cts_q;

    // tracks the line even in reset so no false edge appears on release
    always_ff @(posedge clk) begin
        cts_q <= cts_i;
    end

    logic cts_fall;
    assign cts_fall = cts_q & ~cts_i;

    always_comb begin
        ev.cts_lvl = cts_q;
        ev.cts_chg = cts_q ^ cts_i;
        ev.rep     = bus_mode ? tx_collide : (tx_busy & cts_fall);
    end

    // R5: every change of the CTS input is flagged
    a_r5_cts_edge: assert property (@(posedge clk) disable iff (rst)
        (cts_i != $past(cts_i)) |-> ev.cts_chg);

    // R10: no repeat in point-to-point mode while idle
    a_r10_p2p_idle: assert property (@(posedge clk) disable iff (rst)
        (!bus_mode && !tx_busy) |-> !ev.rep);

endmodule

// File: rtl/irq_stat_bank.sv
module irq_stat_bank #(
    parameter int          W      = 8,
    parameter logic [W-1:0] FORCED = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mask_we,
    input  logic [W-1:0] mask_wd,
    input  logic         vis,
    input  logic         rd_clr,
    input  logic [W-1:0] ev,
    output logic [W-1:0] stat,
    output logic [W-1:0] mask,
    output logic [W-1:0] pend
);

    logic [W-1:0] admit;
    logic [W-1:0] stat_kept;

    assign admit     = ev & ~FORCED & ({W{vis}} | ~mask);
    assign stat_kept = rd_clr ? '0 : stat;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '1;
            stat <= '0;
        end else begin
            if (mask_we) mask <= mask_wd | FORCED;
            stat <= stat_kept | admit;
        end
    end

    assign pend = stat & ~mask;

    // R1: masks come out of reset fully set
    a_r1_mask_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask == '1 && stat == '0));

    // R4: with visibility off, no masked bit becomes newly set
    a_r4_drop_hidden: assert property (@(posedge clk) disable iff (rst)
        !vis |=> ((stat & ~$past(stat) & $past(mask)) == '0));

    // R6: a read with no incoming event empties the register
    a_r6_clear: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && ev == '0) |=> (stat == '0));

    // R7: enabled events in the read cycle survive the clear
    a_r7_keep: assert property (@(posedge clk) disable iff (rst)
        rd_clr |=> ((stat & $past(ev & ~mask)) == $past(ev & ~mask)));

endmodule

// File: rtl/irq_summary.sv
module irq_summary
    import irq_status_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  pend,
    output logic [NBANK-1:0] gsum,
    output logic             irq,
    output logic             vec_valid,
    output logic [IDXW-1:0]  vec_idx
);

    for (genvar b = 0; b < NBANK; b++) begin : g_grp
        assign gsum[b] = |pend[b*DW +: DW];
    end

    assign irq       = |pend;
    assign vec_valid = irq;
    assign vec_idx   = first_set(pend);

    // R9: the presented index always points at an enabled pending source
    a_r9_vec_hits: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> pend[vec_idx]);

    // R8: interrupt line and group summary agree
    a_r8_irq_gsum: assert property (@(posedge clk) disable iff (rst)
        irq == (gsum != '0));

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irq_status_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [SELW-1:0]      wr_sel,
    input  logic [DW-1:0]        wr_data,
    input  logic                 rd_en,
    input  logic [SELW-1:0]      rd_sel,
    output logic [DW-1:0]        rd_data,
    input  logic [DW-1:0]        ev_rx,
    input  logic                 ev_xpr,
    input  logic                 ev_tmr,
    input  logic                 ev_xdu,
    input  logic                 ev_alls,
    input  logic                 tx_collide,
    input  logic                 tx_busy,
    input  logic                 bus_mode,
    input  logic                 cts_i,
    output logic                 irq_o,
    output logic [NBANK-1:0]     gsum_o,
    output logic                 vec_valid_o,
    output logic [IDXW-1:0]      vec_idx_o
);

    ctrl_t    ctrl_q;
    line_ev_t line_ev;

    logic [NBANK-1:0][DW-1:0] ev_bank;
    logic [NBANK-1:0][DW-1:0] stat;
    logic [NBANK-1:0][DW-1:0] mask;
    logic [NBANK-1:0][DW-1:0] pend;
    logic [NBANK-1:0]         mask_we;
    logic [NBANK-1:0]         rd_clr;
    logic [NSRC-1:0]          pend_flat;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en && wr_sel == WR_CTRL) begin
            ctrl_q.vis <= wr_data[0];
        end
    end

    irq_line_events u_line (
        .clk        (clk),
        .rst        (rst),
        .cts_i      (cts_i),
        .bus_mode   (bus_mode),
        .tx_collide (tx_collide),
        .tx_busy    (tx_busy),
        .ev         (line_ev)
    );

    always_comb begin
        ev_bank[0]         = ev_rx;
        ev_bank[1]         = '0;
        ev_bank[1][B_XPR]  = ev_xpr;
        ev_bank[1][B_REP]  = line_ev.rep;
        ev_bank[1][B_CTS]  = line_ev.cts_chg;
        ev_bank[1][B_TMR]  = ev_tmr;
        ev_bank[1][B_XDU]  = ev_xdu;
        ev_bank[1][B_ALLS] = ev_alls;
    end

    always_comb begin
        for (int b = 0; b < NBANK; b++) begin
            mask_we[b] = wr_en && (wr_sel == SELW'(b));
            rd_clr[b]  = rd_en && (rd_sel == SELW'(b));
        end
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        irq_stat_bank #(
            .W      (DW),
            .FORCED (forced_bits(b))
        ) u_bank (
            .clk     (clk),
            .rst     (rst),
            .mask_we (mask_we[b]),
            .mask_wd (wr_data),
            .vis     (ctrl_q.vis),
            .rd_clr  (rd_clr[b]),
            .ev      (ev_bank[b]),
            .stat    (stat[b]),
            .mask    (mask[b]),
            .pend    (pend[b])
        );
        assign pend_flat[b*DW +: DW] = pend[b];
    end

    irq_summary u_sum (
        .clk       (clk),
        .rst       (rst),
        .pend      (pend_flat),
        .gsum      (gsum_o),
        .irq       (irq_o),
        .vec_valid (vec_valid_o),
        .vec_idx   (vec_idx_o)
    );

    always_comb begin
        rd_data = '0;
        case (rd_sel)
            RD_STAT_A: rd_data = stat[0];
            RD_STAT_B: rd_data = stat[1];
            RD_GSUM:   rd_data[NBANK-1:0] = gsum_o;
            RD_LINE:   rd_data[0] = line_ev.cts_lvl;
            default:   rd_data = '0;
        endcase
    end

    // R5: a CTS change admitted under visibility lands in B2
    a_r5_cts_recorded: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.vis && line_ev.cts_chg) |=> stat[1][B_CTS]);

    // R11: unused register B positions never read as set
    a_r11_unused_zero: assert property (@(posedge clk) disable iff (rst)
        (stat[1] & B_UNUSED) == '0);

    // R3: a fully masked register never reaches the interrupt line
    a_r3_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (mask[0] == '1 && mask[1] == '1) |-> !irq_o);

endmodule

// File: tb/irq_status_ctrl_tb.sv
module irq_status_ctrl_tb_top;
    import irq_status_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst = 1'b1;
    logic          wr_en = 0, rd_en = 0;
    logic [1:0]    wr_sel = 0, rd_sel = 0;
    logic [7:0]    wr_data = 0, ev_rx = 0;
    logic          ev_xpr = 0, ev_tmr = 0, ev_xdu = 0, ev_alls = 0;
    logic          tx_collide = 0, tx_busy = 0, bus_mode = 0, cts_i = 0;
    logic [7:0]    rd_data;
    logic          irq_o, vec_valid_o;
    logic [1:0]    gsum_o;
    logic [3:0]    vec_idx_o;

    irq_status_ctrl dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .ev_rx(ev_rx),
        .ev_xpr(ev_xpr), .ev_tmr(ev_tmr), .ev_xdu(ev_xdu), .ev_alls(ev_alls),
        .tx_collide(tx_collide), .tx_busy(tx_busy), .bus_mode(bus_mode),
        .cts_i(cts_i), .irq_o(irq_o), .gsum_o(gsum_o),
        .vec_valid_o(vec_valid_o), .vec_idx_o(vec_idx_o)
    );

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    logic [7:0] m_sa, m_sb, m_ma, m_mb;
    logic       m_vis, m_cts;

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    function automatic logic [15:0] m_pend();
        return {m_sb & ~m_mb, m_sa & ~m_ma};
    endfunction

    function automatic logic [7:0] m_rd();
        logic [15:0] p;
        p = m_pend();
        case (rd_sel)
            2'd0: return m_sa;
            2'd1: return m_sb;
            2'd2: return {6'b0, |p[15:8], |p[7:0]};
            default: return {7'b0, m_cts};
        endcase
    endfunction

    function automatic logic [3:0] m_idx();
        logic [15:0] p;
        logic [3:0]  r;
        p = m_pend();
        r = 0;
        for (int i = 15; i >= 0; i--) if (p[i]) r = 4'(i);
        return r;
    endfunction

    task automatic model_step();
        logic       chg, rep;
        logic [7:0] eb, sa_set, sb_set;
        if (rst) begin
            m_sa = 0; m_sb = 0; m_ma = 8'hFF; m_mb = 8'hFF; m_vis = 0;
        end else begin
            chg = (cts_i != m_cts);
            rep = bus_mode ? tx_collide : (tx_busy && m_cts && !cts_i);
            eb  = {2'b00, ev_alls, ev_xdu, ev_tmr, chg, rep, ev_xpr};
            sa_set = ev_rx & (m_vis ? 8'hFF : ~m_ma);
            sb_set = eb & (m_vis ? 8'hFF : ~m_mb);
            m_sa = ((rd_en && rd_sel == 2'd0) ? 8'h00 : m_sa) | sa_set;
            m_sb = ((rd_en && rd_sel == 2'd1) ? 8'h00 : m_sb) | sb_set;
            if (wr_en && wr_sel == 2'd0) m_ma = wr_data;
            if (wr_en && wr_sel == 2'd1) m_mb = wr_data | 8'hC0;
            if (wr_en && wr_sel == 2'd2) m_vis = wr_data[0];
        end
        m_cts = cts_i;
    endtask

    // one clock: read data checked before the edge, outputs after it
    task automatic cyc(input string r);
        logic [15:0] p;
        #1;
        if (!rst) chk({r, " rd_data"}, rd_data, m_rd());
        @(posedge clk);
        model_step();
        @(negedge clk);
        p = m_pend();
        chk({r, " irq"},   irq_o, |p);
        chk({r, " gsum"},  gsum_o, {|p[15:8], |p[7:0]});
        chk({r, " vvalid"}, vec_valid_o, |p);
        chk({r, " vidx"},  vec_idx_o, m_idx());
        wr_en = 0; rd_en = 0; ev_rx = 0; ev_xpr = 0; ev_tmr = 0;
        ev_xdu = 0; ev_alls = 0; tx_collide = 0;
    endtask

    task automatic rd_now(input logic [1:0] sel, input logic [7:0] exp, input string r);
        rd_sel = sel;
        #1;
        chk(r, rd_data, exp);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d, input string r);
        wr_en = 1; wr_sel = sel; wr_data = d;
        cyc(r);
    endtask

    task automatic clr(input logic [1:0] sel);
        rd_en = 1; rd_sel = sel;
        cyc("R6");
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        m_cts = 0; m_sa = 0; m_sb = 0; m_ma = 8'hFF; m_mb = 8'hFF; m_vis = 0;
        @(negedge clk);
        repeat (3) cyc("R1");
        rst = 0;
        cyc("R1");
        chk("R1 irq after reset", irq_o, 0);
        chk("R1 gsum after reset", gsum_o, 0);
        rd_now(2'd0, 8'h00, "R1 stat A after reset");

        // masked event with visibility off is dropped
        ev_rx = 8'h08; cyc("R4");
        rd_now(2'd0, 8'h00, "R4 hidden event not latched");
        chk("R3 no irq from masked", irq_o, 0);

        // enable low nibble of A
        wr(2'd0, 8'hF0, "R12");
        ev_rx = 8'h02; cyc("R2");
        chk("R2 irq enabled source", irq_o, 1);
        chk("R8 gsum A", gsum_o, 2'b01);
        chk("R9 index", vec_idx_o, 4'd1);
        rd_now(2'd2, 8'h01, "R8 summary read");

        rd_en = 1; rd_now(2'd0, 8'h02, "R6 read returns latched");
        cyc("R6");
        chk("R8 irq drops after clear", irq_o, 0);
        rd_now(2'd0, 8'h00, "R6 cleared");

        // event coinciding with a clearing read
        ev_rx = 8'h01; cyc("R7");
        ev_rx = 8'h04; rd_en = 1; rd_now(2'd0, 8'h01, "R7 read value");
        cyc("R7");
        rd_now(2'd0, 8'h04, "R7 new event kept");
        chk("R7 index", vec_idx_o, 4'd2);
        clr(2'd0);

        // visibility on: masked event is recorded but silent
        wr(2'd2, 8'h01, "R12");
        ev_rx = 8'h40; cyc("R4");
        chk("R3 masked visible no irq", irq_o, 0);
        chk("R3 masked no gsum", gsum_o, 2'b00);
        rd_now(2'd0, 8'h40, "R4 visible masked event");
        wr(2'd0, 8'hB0, "R2");
        chk("R2 unmask raises irq", irq_o, 1);
        chk("R9 index 6", vec_idx_o, 4'd6);
        clr(2'd0);
        wr(2'd2, 8'h00, "R12");

        // CTS change on both edges, line level read
        wr(2'd1, 8'h00, "R11");
        cts_i = 1; cyc("R5");
        chk("R5 rise irq", irq_o, 1);
        chk("R5 rise index", vec_idx_o, 4'd10);
        chk("R8 gsum B", gsum_o, 2'b10);
        rd_now(2'd1, 8'h04, "R5 rise latched");
        clr(2'd1);
        rd_now(2'd3, 8'h01, "R5 level high");
        cts_i = 0; cyc("R5");
        chk("R5 fall index", vec_idx_o, 4'd10);
        rd_now(2'd3, 8'h00, "R5 level low");
        clr(2'd1);

        // transmit repeat
        bus_mode = 1; tx_collide = 1; cyc("R10");
        rd_now(2'd1, 8'h02, "R10 bus collision");
        clr(2'd1);
        bus_mode = 0; cts_i = 1; cyc("R10");
        clr(2'd1);
        tx_busy = 1; cts_i = 0; cyc("R10");
        rd_now(2'd1, 8'h06, "R10 cts withdrawn during char");
        clr(2'd1);
        tx_busy = 0; cts_i = 1; cyc("R10");
        cts_i = 0; cyc("R10");
        rd_now(2'd1, 8'h04, "R10 idle fall no repeat");
        clr(2'd1);

        // layout of B and unused bits
        ev_xpr = 1; ev_alls = 1; ev_xdu = 1; cyc("R11");
        rd_now(2'd1, 8'h31, "R11 layout");
        chk("R11 index", vec_idx_o, 4'd8);
        clr(2'd1);

        // priority and masking of a latched bit
        ev_rx = 8'h48; ev_tmr = 1; cyc("R9");
        chk("R9 A before B", vec_idx_o, 4'd3);
        clr(2'd0);
        chk("R9 B timer index", vec_idx_o, 4'd11);
        wr(2'd1, 8'h08, "R3");
        chk("R3 masked latched bit silent", irq_o, 0);
        chk("R3 gsum silent", gsum_o, 2'b00);
        wr(2'd1, 8'h00, "R2");
        chk("R2 re-enable", irq_o, 1);
        clr(2'd1);

        // random mix
        for (int i = 0; i < 600; i++) begin
            ev_rx      = 8'($urandom) & 8'($urandom) & 8'($urandom);
            ev_xpr     = ($urandom % 6) == 0;
            ev_tmr     = ($urandom % 6) == 0;
            ev_xdu     = ($urandom % 8) == 0;
            ev_alls    = ($urandom % 8) == 0;
            tx_collide = ($urandom % 5) == 0;
            if (($urandom % 7) == 0) bus_mode = ~bus_mode;
            if (($urandom % 3) == 0) tx_busy = ~tx_busy;
            if (($urandom % 4) == 0) cts_i = ~cts_i;
            rd_en  = ($urandom % 3) == 0;
            rd_sel = 2'($urandom);
            wr_en  = ($urandom % 5) == 0;
            wr_sel = 2'($urandom);
            wr_data = 8'($urandom);
            cyc("R8");
        end

        summary();
        $finish;
    end

endmodule